// File: doc/BRIEF.md
# Self-Correcting Sixteen-State Sequencer

This block is a small control sequencer with sixteen legal states. The state is held as a seven-bit single-error-correcting codeword, not as a plain binary index. Each cycle, a combinational corrector maps the stored word to the nearest legal codeword. The next-state table then works from that repaired index. The updated index is re-encoded and written back. A single inverted bit in the state register therefore never changes the state sequence. The block repairs it in the cycle it shows up and raises a one-cycle flag.

The transition rules are fixed and prioritised over an eight-bit control input. One control bit, chosen by the current state, advances the machine by one. A second bit, chosen four positions further on, sends it to the mirrored state. If neither is set, the state holds. An asynchronous active-low reset and a synchronous reset both return the machine to state 0.

An upset-injection input XORs a mask into the codeword as it is written. This emulates radiation-induced bit flips. In normal use the mask is tied to zero.

Top module: `hamming_state_reg`

## Requirements
- R1: The codeword has seven bit positions, numbered 1 to 7 and stored in register bits 0 to 6. Positions 1, 2 and 4 carry parity. Index bits 0 to 3 sit at positions 3, 5, 6 and 7. The parity bit at position 2^k is the XOR of every other position whose number has bit k set. As a consequence, a word with both positions 1 and 2 inverted decodes as the state with index bit 0 inverted, and the flag is raised.
- R2: While `rstN` is low, the register holds the all-zero codeword of state 0. `stateIdx` reads 0 and `fixFlag` is low.
- R3: When `syncRst` is high at a clock edge, the register loads state 0 with no error. This overrides the control input and any upset mask.
- R4: If control bit (s mod 8) is set, where s is the repaired current index, the next state is (s+1) mod 16.
- R5: Otherwise, if control bit ((s+4) mod 8) is set, the next state is 15-s.
- R6: If neither selected bit is set, the state holds. The other six control bits have no effect.
- R7: At a non-reset clock edge, the stored word is the encoded next state XOR `upsetMask`. With exactly one mask bit set, `stateIdx` shows the intended state in the following cycle and `fixFlag` is high. The next transition starts from that repaired index.
- R8: `fixFlag` is low in any cycle where the register holds a legal codeword, that is, after a clean load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncRst | input | 1 | Synchronous reset to state 0 |
| ctrl | input | 8 | Transition condition bits |
| upsetMask | input | 7 | Bits inverted in the codeword at the next write (tie to zero in use) |
| stateIdx | output | 4 | Repaired current state index |
| fixFlag | output | 1 | High in a cycle whose stored word needed correction |

## Verification
The hardest case is a flipped bit that lands in the same cycle as a transition. In that case the repair and the next-state lookup must compose correctly. Any bit position can be affected, and the state can be any one of sixteen. The stimulus drives the mask input together with control patterns that select advance, mirror or hold. It sweeps all seven positions with directed cases, then runs a long random phase of sparse control and single-bit masks against a behavioural model. A double flip of the first two parity positions checks the bit layout through a predictable miscorrection.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  // Strobes from the transition control to the state datapath
  typedef struct packed {
    logic advance;
    logic mirror;
  } stepStrobe_t;
endpackage

// File: rtl/hsr_control.sv
module hsr_control
  import hsr_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int CTRL_W = 8
) (
  input  logic [DATA_W-1:0] curIdx,
  input  logic [CTRL_W-1:0] ctrl,
  output stepStrobe_t       strobe
);
  localparam int SEL_W = (CTRL_W > 1) ? $clog2(CTRL_W) : 1;

  logic [SEL_W-1:0] primSel;
  logic [SEL_W-1:0] altSel;

  always_comb begin
    primSel = SEL_W'(int'(curIdx) % CTRL_W);
    altSel  = SEL_W'((int'(curIdx) + CTRL_W / 2) % CTRL_W);
    strobe.advance = ctrl[primSel];
    strobe.mirror  = !ctrl[primSel] && ctrl[altSel];
  end
endmodule

// File: rtl/hsr_datapath.sv
module hsr_datapath
  import hsr_pkg::*;
#(
  parameter int PAR_W = 3,
  localparam int CODE_W = (1 << PAR_W) - 1,
  localparam int DATA_W = CODE_W - PAR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncRst,
  input  stepStrobe_t       strobe,
  input  logic [CODE_W-1:0] upsetMask,
  output logic [DATA_W-1:0] curIdx,
  output logic              fixFlag
);
  // Syndrome: XOR of the position numbers of all set bits
  function automatic logic [PAR_W-1:0] syndromeOf(input logic [CODE_W-1:0] w);
    logic [PAR_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CODE_W; p++)
      if (w[p-1]) s = s ^ PAR_W'(p);
    return s;
  endfunction

  function automatic logic [CODE_W-1:0] encodeOf(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] w;
    logic [PAR_W-1:0]  s;
    int k;
    w = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++)
      if ((p & (p - 1)) != 0) begin
        w[p-1] = d[k];
        k++;
      end
    s = syndromeOf(w);
    for (int j = 0; j < PAR_W; j++) w[(1 << j) - 1] = s[j];
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] extractOf(input logic [CODE_W-1:0] w);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++)
      if ((p & (p - 1)) != 0) begin
        d[k] = w[p-1];
        k++;
      end
    return d;
  endfunction

  logic [CODE_W-1:0] codeReg;
  logic [PAR_W-1:0]  syn;
  logic [CODE_W-1:0] flipVec;
  logic [CODE_W-1:0] fixedWord;
  logic [DATA_W-1:0] nextIdx;

  assign syn = syndromeOf(codeReg);

  // One comparator per position: invert the bit the syndrome points at
  for (genvar p = 1; p <= CODE_W; p++) begin : g_flip
    assign flipVec[p-1] = (syn == PAR_W'(p));
  end

  assign fixedWord = codeReg ^ flipVec;
  assign curIdx    = extractOf(fixedWord);
  assign fixFlag   = (syn != '0);

  always_comb begin
    if (strobe.advance)     nextIdx = curIdx + 1'b1;
    else if (strobe.mirror) nextIdx = ~curIdx;
    else                    nextIdx = curIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        codeReg <= encodeOf('0);
    else if (syncRst) codeReg <= encodeOf('0);
    else              codeReg <= encodeOf(nextIdx) ^ upsetMask;
  end

  // R2: asynchronous reset holds the state-0 codeword
  always @(posedge clk) begin
    if (!rstN) assert_reset_code_R2: assert (codeReg == '0 && !fixFlag);
  end

  // R8: a word written without a mask needs no repair
  assert_clean_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!syncRst && upsetMask == '0) |=> (syndromeOf(codeReg) == '0));
endmodule

// File: rtl/hamming_state_reg.sv
module hamming_state_reg
  import hsr_pkg::*;
#(
  parameter int PAR_W = 3,
  parameter int CTRL_W = 8,
  localparam int CODE_W = (1 << PAR_W) - 1,
  localparam int DATA_W = CODE_W - PAR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncRst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [CODE_W-1:0] upsetMask,
  output logic [DATA_W-1:0] stateIdx,
  output logic              fixFlag
);
  stepStrobe_t strobe;

  hsr_control #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_ctl (
    .curIdx (stateIdx),
    .ctrl   (ctrl),
    .strobe (strobe)
  );

  hsr_datapath #(.PAR_W(PAR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .syncRst   (syncRst),
    .strobe    (strobe),
    .upsetMask (upsetMask),
    .curIdx    (stateIdx),
    .fixFlag   (fixFlag)
  );

  assert_sync_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    syncRst |=> (stateIdx == '0 && !fixFlag));

  assert_flip_flagged_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!syncRst && $onehot(upsetMask)) |=> fixFlag);

  assert_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!syncRst && strobe.advance && $countones(upsetMask) <= 1)
      |=> stateIdx == DATA_W'($past(stateIdx) + 1'b1));

  assert_mirror_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!syncRst && strobe.mirror && $countones(upsetMask) <= 1)
      |=> stateIdx == ~$past(stateIdx));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!syncRst && !strobe.advance && !strobe.mirror && $countones(upsetMask) <= 1)
      |=> stateIdx == $past(stateIdx));
endmodule

// File: tb/hamming_state_reg_test.sv
module hamming_state_reg_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       syncRst = 1'b0;
  logic [7:0] ctrl = '0;
  logic [6:0] upsetMask = '0;
  logic [3:0] stateIdx;
  logic       fixFlag;

  int nChecks = 0;
  int nFails = 0;
  int refState = 0;
  bit expFlag = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  hamming_state_reg uut (
    .clk(clk), .rstN(rstN), .syncRst(syncRst), .ctrl(ctrl),
    .upsetMask(upsetMask), .stateIdx(stateIdx), .fixFlag(fixFlag)
  );

  function automatic int nextOf(int s, logic [7:0] c);
    if (c[s % 8]) return (s + 1) % 16;
    if (c[(s + 4) % 8]) return 15 - s;
    return s;
  endfunction

  task automatic compare(string tag);
    nChecks++;
    if (stateIdx !== 4'(refState) || fixFlag !== expFlag) begin
      nFails++;
      $display("FAIL %s: stateIdx=%0d fixFlag=%0b expected stateIdx=%0d fixFlag=%0b",
               tag, stateIdx, fixFlag, refState, expFlag);
    end
  endtask

  task automatic step(logic [7:0] c, logic [6:0] m, logic sr, string tag);
    @(negedge clk);
    ctrl = c; upsetMask = m; syncRst = sr;
    @(posedge clk);
    #2;
    if (sr) begin
      refState = 0; expFlag = 0;
    end else begin
      refState = nextOf(refState, c);
      expFlag = (m != 0);
      if (m == 7'b0000011) refState = refState ^ 1;
    end
    compare(tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish();
  end

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    refState = 0; expFlag = 0;
    compare("R2 reset state");
    @(negedge clk); rstN = 1'b1;

    step(8'h00, '0, 0, "R6 hold at 0");
    step(8'h01, '0, 0, "R4 advance 0->1");
    step(8'h20, '0, 0, "R5 mirror 1->14");
    step(8'h44, '0, 0, "R4 priority over mirror 14->15");
    step(8'h77, '0, 0, "R6 unselected bits ignored at 15");
    step(8'h08, '0, 0, "R5 mirror 15->0");
    // R7: every bit position flipped while holding, then clean (R8)
    for (int b = 0; b < 7; b++) begin
      step(8'h00, 7'(1 << b), 0, "R7 flip while holding");
      step(8'h00, '0, 0, "R8 flag clears after repair");
    end
    // R7: flips combined with transitions
    for (int b = 0; b < 7; b++) begin
      step(8'(1 << (refState % 8)), 7'(1 << b), 0, "R7 flip with advance");
      step(8'(1 << ((refState + 4) % 8)), 7'(1 << b), 0, "R7 flip with mirror");
    end
    step(8'h00, 7'b0000011, 0, "R1 parity layout double flip");
    step(8'h00, '0, 0, "R1 after layout check");
    step(8'hFF, 7'b0010000, 1, "R3 sync reset overrides mask");
    step(8'h00, '0, 0, "R3 state 0 after sync reset");

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] c;
      logic [6:0] m;
      logic sr;
      c = 8'(1 << $urandom_range(7, 0)) & ($urandom_range(1, 0) ? 8'hFF : 8'h00);
      if ($urandom_range(5, 0) == 0) c = 8'($urandom);
      m = ($urandom_range(3, 0) == 0) ? 7'(1 << $urandom_range(6, 0)) : 7'b0;
      sr = ($urandom_range(199, 0) == 0);
      step(c, m, sr, "R7 random flips against model");
    end
    finish();
  end
endmodule